// File: doc/BRIEF.md
# Peak-Centred Triggered Snapshot Capture

This block takes a multi-channel stream of parallel sample words at a fixed raw rate. All channels are latched together on each raw strobe. It keeps one strobe out of every N, where N is programmable. Each kept word goes out on a write port to a circular event memory, together with the number of particle pulses seen over the same N raw periods. Acquisition runs without pause, so every kept sample is written whether or not an event is being captured.

One selected channel is watched for a magnitude above a programmable threshold. A crossing opens a short search for the largest magnitude. The snapshot is then closed so that this peak sits at the centre of a window of 2*H kept samples, with H samples before the peak and H samples from the peak onward. On the cycle the final sample of that window is written, the block reports the window's start address, the peak address and the peak magnitude. A crossing is only accepted when no capture is in progress and the downstream slot-free input is high.

Top module: `capt_snapshot`

## Requirements
- R1: While reset is held, `wr_en` and `evt_valid` are low. The first kept sample after reset is written at address 0.
- R2: With `cfg_decim_m1` = N-1, where N runs from 1 to 64, exactly one sample is kept for every N raw strobes: the one on the N-th, or last, strobe of each group.
- R3: A kept sample is written two clock cycles after its strobe. `wr_data[SW*i +: SW]` holds channel i of that strobe, and the top CW bits hold the count.
- R4: Consecutive kept samples go to consecutive addresses, which wrap modulo DEPTH.
- R5: The count of a kept sample is the number of clock cycles with `cnt_pulse` high. It covers the cycles after the previous kept strobe up to and including its own strobe cycle. It saturates at 2^CW-1.
- R6: A capture starts when the block is idle, `slot_free` is high and the magnitude of the selected channel of a kept sample is strictly greater than `cfg_thresh`. A magnitude equal to the threshold does not start one.
- R7: The peak is the largest magnitude among SEARCH_LEN kept samples, starting with the crossing sample. Among equal magnitudes the earliest is kept. The magnitude of the most negative code is 2^(SW-1).
- R8: `evt_start_addr` = peak address - H and the last sample is at peak address + H - 1, both modulo DEPTH. `evt_valid` is high for one cycle, in the same cycle as the write of that last sample.
- R9: H is `cfg_half_len`, clamped into the range SEARCH_LEN+1 to DEPTH/2. The value is taken at the crossing.
- R10: Crossings that occur while a capture is in progress, or while `slot_free` is low, are ignored.
- R11: Writes continue without a gap through and after captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Raw sample strobe, one cycle per raw period |
| smp_data | input | NCH*SW | All channels of the raw sample, channel 0 in the low bits |
| cnt_pulse | input | 1 | Particle pulse, counted once per cycle it is high |
| cfg_decim_m1 | input | DCW | Decimation factor minus one |
| cfg_half_len | input | AW | Requested half window H in kept samples |
| cfg_trig_ch | input | CHW | Channel watched for triggers |
| cfg_thresh | input | SW | Trigger magnitude threshold |
| slot_free | input | 1 | A free event slot exists downstream |
| wr_en | output | 1 | Event memory write strobe |
| wr_addr | output | AW | Event memory write address |
| wr_data | output | NCH*SW+CW | Count and channel samples |
| evt_valid | output | 1 | One-cycle event report |
| evt_start_addr | output | AW | First address of the captured window |
| evt_peak_addr | output | AW | Address of the peak sample |
| evt_peak_mag | output | SW | Peak magnitude |

## Verification
The bench builds the block with two signed 16-bit channels, a 4-bit count field, a 32-entry memory and a four-sample peak search. The narrow count field lets saturation be reached within one decimation group of a few raw periods. The small memory lets a window wrap past address 0 within a short run. A decimation sweep runs from 1 to the maximum of 64. The capture sequence then covers the centring of the window, ignored crossings, a value equal to the threshold, the most negative code and the lower clamp on H.

// File: rtl/capt_pkg.sv
package capt_pkg;
   typedef enum logic [1:0] {
      TS_IDLE = 2'd0,
      TS_SRCH = 2'd1,
      TS_POST = 2'd2
   } trig_st_t;
endpackage

// File: rtl/capt_decim.sv
module capt_decim #(
   parameter int NCH = 2,
   parameter int SW = 16,
   parameter int CW = 8,
   parameter int DCW = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [NCH*SW-1:0]  smp_data,
   input  logic               cnt_pulse,
   input  logic [DCW-1:0]     cfg_decim_m1,
   output logic               k_valid,
   output logic [NCH*SW-1:0]  k_data,
   output logic [CW-1:0]      k_cnt
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [DCW-1:0] phase_q;
   logic [CW-1:0]  acc_q;
   logic [CW-1:0]  acc_sum;
   logic           keep;

   assign keep = smp_valid && (phase_q >= cfg_decim_m1);

   always_comb begin
      if (acc_q == CMAX) acc_sum = CMAX;
      else               acc_sum = acc_q + {{(CW-1){1'b0}}, cnt_pulse};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         acc_q   <= '0;
         k_valid <= 1'b0;
         k_data  <= '0;
         k_cnt   <= '0;
      end else begin
         k_valid <= keep;
         if (smp_valid) phase_q <= keep ? '0 : phase_q + 1'b1;
         if (keep) begin
            k_data <= smp_data;
            k_cnt  <= acc_sum;
            acc_q  <= '0;
         end else begin
            acc_q  <= acc_sum;
         end
      end
   end

   // R2
   keep_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      k_valid |-> $past(smp_valid));

   // R5
   cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q == CMAX && !keep) |=> (acc_q == CMAX));
endmodule

// File: rtl/capt_ring_wr.sv
module capt_ring_wr #(
   parameter int NCH = 2,
   parameter int SW = 16,
   parameter int CW = 8,
   parameter int AW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  k_valid,
   input  logic [NCH*SW-1:0]     k_data,
   input  logic [CW-1:0]         k_cnt,
   output logic [AW-1:0]         ptr,
   output logic                  wr_en,
   output logic [AW-1:0]         wr_addr,
   output logic [NCH*SW+CW-1:0]  wr_data
);
   logic [AW-1:0] ptr_q;
   assign ptr = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= k_valid;
         if (k_valid) begin
            wr_addr <= ptr_q;
            wr_data <= {k_cnt, k_data};
            ptr_q   <= ptr_q + 1'b1;
         end
      end
   end

   // R4
   addr_follows_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      k_valid |=> (wr_en && wr_addr == $past(ptr_q)));
endmodule

// File: rtl/capt_trigger.sv
module capt_trigger
   import capt_pkg::*;
#(
   parameter int NCH = 2,
   parameter int SW = 16,
   parameter int AW = 8,
   parameter int SEARCH_LEN = 4,
   parameter bit SIGNED_SMP = 1'b1,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               k_valid,
   input  logic [NCH*SW-1:0]  k_data,
   input  logic [AW-1:0]      ptr,
   input  logic [CHW-1:0]     cfg_trig_ch,
   input  logic [SW-1:0]      cfg_thresh,
   input  logic [AW-1:0]      cfg_half_len,
   input  logic               slot_free,
   output logic               evt_valid,
   output logic [AW-1:0]      evt_start_addr,
   output logic [AW-1:0]      evt_peak_addr,
   output logic [SW-1:0]      evt_peak_mag
);
   localparam int NSEL = 1 << CHW;
   localparam int DEPTH = 1 << AW;
   localparam int SCW = $clog2(SEARCH_LEN + 1);
   localparam logic [AW:0] H_LO = (AW+1)'(SEARCH_LEN + 1);
   localparam logic [AW:0] H_HI = (AW+1)'(DEPTH / 2);

   logic [SW-1:0] ch_arr [NSEL];
   logic [SW-1:0] sel_raw;
   logic [SW-1:0] mag;
   logic [AW-1:0] eff_h;
   logic [AW-1:0] end_addr;

   trig_st_t       st_q;
   logic [SW-1:0]  pk_mag_q;
   logic [AW-1:0]  pk_addr_q;
   logic [AW-1:0]  h_q;
   logic [SCW-1:0] srch_q;

   for (genvar i = 0; i < NSEL; i++) begin : g_unpack
      if (i < NCH) begin : g_ch
         assign ch_arr[i] = k_data[i*SW +: SW];
      end else begin : g_pad
         assign ch_arr[i] = '0;
      end
   end

   assign sel_raw = ch_arr[cfg_trig_ch];

   if (SIGNED_SMP) begin : g_abs
      assign mag = sel_raw[SW-1] ? (~sel_raw + 1'b1) : sel_raw;
   end else begin : g_plain
      assign mag = sel_raw;
   end

   always_comb begin
      if ({1'b0, cfg_half_len} < H_LO)      eff_h = H_LO[AW-1:0];
      else if ({1'b0, cfg_half_len} > H_HI) eff_h = H_HI[AW-1:0];
      else                                  eff_h = cfg_half_len;
   end

   assign end_addr = pk_addr_q + h_q - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q           <= TS_IDLE;
         pk_mag_q       <= '0;
         pk_addr_q      <= '0;
         h_q            <= '0;
         srch_q         <= '0;
         evt_valid      <= 1'b0;
         evt_start_addr <= '0;
         evt_peak_addr  <= '0;
         evt_peak_mag   <= '0;
      end else begin
         evt_valid <= 1'b0;
         case (st_q)
            TS_IDLE: begin
               if (k_valid && slot_free && (mag > cfg_thresh)) begin
                  pk_mag_q  <= mag;
                  pk_addr_q <= ptr;
                  h_q       <= eff_h;
                  srch_q    <= SCW'(SEARCH_LEN - 1);
                  st_q      <= (SEARCH_LEN == 1) ? TS_POST : TS_SRCH;
               end
            end
            TS_SRCH: begin
               if (k_valid) begin
                  if (mag > pk_mag_q) begin
                     pk_mag_q  <= mag;
                     pk_addr_q <= ptr;
                  end
                  if (srch_q <= SCW'(1)) st_q <= TS_POST;
                  else                   srch_q <= srch_q - 1'b1;
               end
            end
            TS_POST: begin
               if (k_valid && (ptr == end_addr)) begin
                  evt_valid      <= 1'b1;
                  evt_start_addr <= pk_addr_q - h_q;
                  evt_peak_addr  <= pk_addr_q;
                  evt_peak_mag   <= pk_mag_q;
                  st_q           <= TS_IDLE;
               end
            end
            default: st_q <= TS_IDLE;
         endcase
      end
   end

   // R10
   start_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != TS_IDLE && $past(st_q) == TS_IDLE) |-> $past(slot_free && k_valid));

   // R8
   evt_from_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> ($past(st_q) == TS_POST && st_q == TS_IDLE));

   // R9
   half_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> ({1'b0, AW'(evt_peak_addr - evt_start_addr)} >= H_LO));
endmodule

// File: rtl/capt_snapshot.sv
module capt_snapshot #(
   parameter int NCH = 2,
   parameter int SW = 16,
   parameter int CW = 8,
   parameter int AW = 8,
   parameter int MAX_DECIM = 64,
   parameter int SEARCH_LEN = 4,
   parameter bit SIGNED_SMP = 1'b1,
   localparam int DCW = $clog2(MAX_DECIM),
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int DW = NCH*SW + CW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [NCH*SW-1:0]  smp_data,
   input  logic               cnt_pulse,
   input  logic [DCW-1:0]     cfg_decim_m1,
   input  logic [AW-1:0]      cfg_half_len,
   input  logic [CHW-1:0]     cfg_trig_ch,
   input  logic [SW-1:0]      cfg_thresh,
   input  logic               slot_free,
   output logic               wr_en,
   output logic [AW-1:0]      wr_addr,
   output logic [DW-1:0]      wr_data,
   output logic               evt_valid,
   output logic [AW-1:0]      evt_start_addr,
   output logic [AW-1:0]      evt_peak_addr,
   output logic [SW-1:0]      evt_peak_mag
);
   if (NCH < 1) begin : g_bad_nch
      $error("capt_snapshot: NCH must be at least 1");
   end
   if (SW < 2 || CW < 1) begin : g_bad_width
      $error("capt_snapshot: SW must be >= 2 and CW >= 1");
   end
   if (MAX_DECIM < 2 || (1 << DCW) != MAX_DECIM) begin : g_bad_decim
      $error("capt_snapshot: MAX_DECIM must be a power of two >= 2");
   end
   if (SEARCH_LEN < 1 || (SEARCH_LEN + 1) > (1 << (AW-1))) begin : g_bad_search
      $error("capt_snapshot: SEARCH_LEN must be in 1 .. DEPTH/2-1");
   end

   logic              k_valid;
   logic [NCH*SW-1:0] k_data;
   logic [CW-1:0]     k_cnt;
   logic [AW-1:0]     ptr;

   capt_decim #(.NCH(NCH), .SW(SW), .CW(CW), .DCW(DCW)) decim_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .cnt_pulse(cnt_pulse), .cfg_decim_m1(cfg_decim_m1),
      .k_valid(k_valid), .k_data(k_data), .k_cnt(k_cnt)
   );

   capt_ring_wr #(.NCH(NCH), .SW(SW), .CW(CW), .AW(AW)) ring_i (
      .clk(clk), .rst_n(rst_n), .k_valid(k_valid), .k_data(k_data),
      .k_cnt(k_cnt), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

   capt_trigger #(.NCH(NCH), .SW(SW), .AW(AW), .SEARCH_LEN(SEARCH_LEN),
                  .SIGNED_SMP(SIGNED_SMP)) trig_i (
      .clk(clk), .rst_n(rst_n), .k_valid(k_valid), .k_data(k_data),
      .ptr(ptr), .cfg_trig_ch(cfg_trig_ch), .cfg_thresh(cfg_thresh),
      .cfg_half_len(cfg_half_len), .slot_free(slot_free),
      .evt_valid(evt_valid), .evt_start_addr(evt_start_addr),
      .evt_peak_addr(evt_peak_addr), .evt_peak_mag(evt_peak_mag)
   );

   // R8
   evt_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> wr_en);

   // R3
   write_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(smp_valid, 2));
endmodule

// File: tb/capt_snapshot_tb_top.sv
module capt_snapshot_tb_top;
   localparam int NCH = 2;
   localparam int SW = 16;
   localparam int CW = 4;
   localparam int AW = 5;
   localparam int SRCH = 4;
   localparam int DEPTH = 32;

   typedef struct packed {
      int n;
      int np;
      int nper;
      int ecnt;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1, 2, 6, 2},
      '{3, 1, 9, 3},
      '{4, 3, 8, 12},
      '{6, 4, 12, 15},
      '{2, 0, 6, 0},
      '{64, 1, 128, 15}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [31:0]   smp_data = '0;
   logic          cnt_pulse = 1'b0;
   logic [5:0]    cfg_decim_m1 = '0;
   logic [AW-1:0] cfg_half_len = '0;
   logic          cfg_trig_ch = 1'b1;
   logic [15:0]   cfg_thresh = 16'hFFFF;
   logic          slot_free = 1'b1;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [35:0]   wr_data;
   logic          evt_valid;
   logic [AW-1:0] evt_start_addr;
   logic [AW-1:0] evt_peak_addr;
   logic [15:0]   evt_peak_mag;

   capt_snapshot #(.NCH(NCH), .SW(SW), .CW(CW), .AW(AW), .MAX_DECIM(64),
                   .SEARCH_LEN(SRCH), .SIGNED_SMP(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .cnt_pulse(cnt_pulse), .cfg_decim_m1(cfg_decim_m1),
      .cfg_half_len(cfg_half_len), .cfg_trig_ch(cfg_trig_ch),
      .cfg_thresh(cfg_thresh), .slot_free(slot_free), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .evt_valid(evt_valid),
      .evt_start_addr(evt_start_addr), .evt_peak_addr(evt_peak_addr),
      .evt_peak_mag(evt_peak_mag)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int raw_idx, kept, wr_seen, cur_n, cur_ecnt;
   logic [15:0] e0 [256];
   logic [15:0] e1 [256];
   int ev_n;
   logic [AW-1:0] ev_start, ev_paddr, ev_wraddr;
   logic [15:0]   ev_pmag;
   logic          ev_wr;
   bit            done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // write and event monitor, sampled away from the rising edge
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         chk(wr_addr == AW'(wr_seen % DEPTH), "R4", "write address",
             wr_addr, wr_seen % DEPTH);
         chk(wr_data[15:0] == e0[wr_seen % 256], "R2", "kept channel 0",
             wr_data[15:0], e0[wr_seen % 256]);
         chk(wr_data[31:16] == e1[wr_seen % 256], "R3", "channel 1 field",
             wr_data[31:16], e1[wr_seen % 256]);
         chk(wr_data[35:32] == 4'(cur_ecnt), "R5", "count field",
             wr_data[35:32], cur_ecnt);
         wr_seen++;
      end
      if (rst_n && evt_valid) begin
         ev_n++;
         ev_start = evt_start_addr;
         ev_paddr = evt_peak_addr;
         ev_pmag = evt_peak_mag;
         ev_wr = wr_en;
         ev_wraddr = wr_addr;
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      smp_valid = 1'b0;
      cnt_pulse = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!wr_en && !evt_valid, "R1", "outputs low in reset",
          {wr_en, evt_valid}, 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      raw_idx = 0;
      kept = 0;
      wr_seen = 0;
      ev_n = 0;
   endtask

   task automatic raw_period(input logic [15:0] v0, input logic [15:0] v1,
                             input int np);
      for (int c = 0; c < 4; c++) begin
         @(posedge clk);
         #1;
         cnt_pulse = (c < np);
         smp_valid = (c == 3);
         if (c == 3) smp_data = {v1, v0};
      end
      if ((raw_idx % cur_n) == cur_n - 1) begin
         e0[kept % 256] = v0;
         e1[kept % 256] = v1;
         kept++;
      end
      raw_idx++;
   endtask

   task automatic idle(input int cyc);
      @(posedge clk);
      #1;
      smp_valid = 1'b0;
      cnt_pulse = 1'b0;
      repeat (cyc) @(posedge clk);
      #1;
   endtask

   function automatic logic [15:0] ev_val(input int i);
      case (i)
         20: return 16'd1500;
         21: return -16'sd3000;
         22: return 16'd2000;
         23: return 16'd100;
         24, 25, 26: return 16'd5000;
         30: return 16'd5000;
         40: return 16'd1000;
         60: return 16'h8000;
         default: return 16'd0;
      endcase
   endfunction

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      // decimation and count table
      for (int v = 0; v < 6; v++) begin
         cfg_decim_m1 = 6'(VECS[v].n - 1);
         cfg_thresh = 16'hFFFF;
         cur_n = VECS[v].n;
         cur_ecnt = VECS[v].ecnt;
         do_reset();
         for (int p = 0; p < VECS[v].nper; p++)
            raw_period(16'(p + 100), 16'd0, VECS[v].np);
         idle(6);
         chk(wr_seen == VECS[v].nper / VECS[v].n, "R2", "kept sample count",
             wr_seen, VECS[v].nper / VECS[v].n);
      end

      // capture sequence
      cfg_decim_m1 = '0;
      cfg_thresh = 16'd1000;
      cfg_trig_ch = 1'b1;
      cfg_half_len = AW'(6);
      slot_free = 1'b1;
      cur_n = 1;
      cur_ecnt = 0;
      do_reset();
      for (int i = 0; i < 71; i++) begin
         slot_free = !(i >= 30 && i < 40);
         if (i == 45) cfg_half_len = AW'(2);
         raw_period(16'(i), ev_val(i), 0);
         if (i == 29) begin
            chk(ev_n == 1, "R10", "one event despite crossings in capture", ev_n, 1);
            chk(ev_paddr == AW'(21), "R7", "peak address", ev_paddr, 21);
            chk(ev_pmag == 16'd3000, "R7", "peak magnitude", ev_pmag, 3000);
            chk(ev_start == AW'(15), "R8", "window start", ev_start, 15);
            chk(ev_wr && ev_wraddr == AW'(26), "R8", "event with last write",
                ev_wraddr, 26);
         end
         if (i == 39)
            chk(ev_n == 1, "R10", "crossing with no free slot ignored", ev_n, 1);
         if (i == 59)
            chk(ev_n == 1, "R6", "value equal to threshold ignored", ev_n, 1);
      end
      idle(6);
      chk(ev_n == 2, "R6", "second event count", ev_n, 2);
      chk(ev_pmag == 16'h8000, "R7", "most negative magnitude", ev_pmag, 32768);
      chk(ev_paddr == AW'(28), "R7", "wrapped peak address", ev_paddr, 28);
      chk(ev_start == AW'(23), "R9", "clamped half window start", ev_start, 23);
      chk(ev_wr && ev_wraddr == AW'(0), "R9", "clamped window end past wrap",
          ev_wraddr, 0);
      chk(wr_seen == 71, "R11", "no write gap across captures", wr_seen, 71);
      done = 1;
      finish_run();
   end
endmodule